// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt flag for each side of a two-port shared memory. Each side owns one reserved mailbox word at the top of the address space. When one side writes into the other side's mailbox, the other side gets an interrupt. The interrupt stays pending until the receiving side reads its own mailbox. Side A receives at the second-highest address (all ones except bit 0). Side B receives at the highest address (all ones). The mailbox addresses follow from the address width parameter, so a 14-bit array uses 3FFE/3FFF and a 13-bit array uses 1FFE/1FFF.

The block sits next to the memory array and watches the same active-low strobes that the array sees. Every rising clock edge samples them, and the sample taken at an edge counts as one access. Each side also has an active-low busy input, which comes from the arbitration between the sides. While a side's busy input is low, that side's accesses leave both flags unchanged. The two interrupt outputs are active low and are always driven.

Top module: `mbox_irq`

## Requirements
- R1: While rstN is low, and at the first edge after it rises, both aIntN and bIntN are high (no interrupt pending).
- R2: An edge that samples aCeN=0, aWeN=0, aBusyN=1 and aAddr equal to all ones drives bIntN low after that edge.
- R3: An edge that samples bCeN=0, bWeN=0, bBusyN=1 and bAddr equal to all ones except bit 0 drives aIntN low after that edge.
- R4: An edge that samples bCeN=0, bOeN=0, bBusyN=1 and bAddr equal to all ones returns bIntN high, whatever the value of bWeN, unless R2 sets it at the same edge.
- R5: An edge that samples aCeN=0, aOeN=0, aBusyN=1 and aAddr equal to all ones except bit 0 returns aIntN high, whatever the value of aWeN, unless R3 sets it at the same edge.
- R6: An access from a side whose busy input is low neither sets nor clears any flag.
- R7: If a set and a clear of the same flag are sampled at the same edge, the flag ends up pending (output low).
- R8: Accesses that do not meet R2 to R5 leave both flags unchanged. This includes a write to a side's own mailbox, a read of the other side's mailbox, any access with chip enable high, a read with output enable high, and any other address.
- R9: A flag holds its state over any number of idle edges between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aAddr | input | AddrW | Side A address |
| aCeN | input | 1 | Side A chip enable, active low |
| aWeN | input | 1 | Side A write strobe, low = write |
| aOeN | input | 1 | Side A output enable, active low |
| aBusyN | input | 1 | Side A busy, low blocks side A's flag actions |
| bAddr | input | AddrW | Side B address |
| bCeN | input | 1 | Side B chip enable, active low |
| bWeN | input | 1 | Side B write strobe, low = write |
| bOeN | input | 1 | Side B output enable, active low |
| bBusyN | input | 1 | Side B busy, low blocks side B's flag actions |
| aIntN | output | 1 | Side A interrupt, active low |
| bIntN | output | 1 | Side B interrupt, active low |

## Verification
The bench targets the places where the two mailbox addresses are easy to mix up. It checks that a side writing its own mailbox does not interrupt itself, and that a read of the other side's mailbox does not clear anything. A design with swapped decodes would raise or drop the wrong flag in exactly those cases. It also checks that busy blocks the clear as well as the set, since a design that gates only writes would lose a pending interrupt. It drives a set and a clear of the same flag at one edge, where a clear-priority design would drop the interrupt. A long random run then hits the mailbox addresses often, with mixed strobe and busy values, and compares the outputs against the model on every cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Per-edge flag actions handed from decode to the flag registers.
  typedef struct packed {
    logic setA;  // side B posted into side A's mailbox
    logic clrA;  // side A read its own mailbox
    logic setB;  // side A posted into side B's mailbox
    logic clrB;  // side B read its own mailbox
  } mboxStrobeT;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int AddrW = 14,
  parameter logic [AddrW-1:0] InboxAddr = '1,
  parameter logic [AddrW-1:0] OutboxAddr = '1
) (
  input  logic [AddrW-1:0] addr,
  input  logic             ceN,
  input  logic             weN,
  input  logic             oeN,
  input  logic             busyN,
  output logic             postMsg,
  output logic             takeMsg
);
  logic active;

  // busy low blocks every flag action of this side
  assign active  = !ceN && busyN;
  assign postMsg = active && !weN && (addr == OutboxAddr);
  assign takeMsg = active && !oeN && (addr == InboxAddr);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int AddrW = 14
) (
  input  logic [AddrW-1:0] aAddr,
  input  logic             aCeN,
  input  logic             aWeN,
  input  logic             aOeN,
  input  logic             aBusyN,
  input  logic [AddrW-1:0] bAddr,
  input  logic             bCeN,
  input  logic             bWeN,
  input  logic             bOeN,
  input  logic             bBusyN,
  output mboxStrobeT       strobes
);
  localparam logic [AddrW-1:0] TopAddr  = '1;
  localparam logic [AddrW-1:0] NextAddr = TopAddr - 1'b1;

  logic aPost, aTake, bPost, bTake;

  // side A receives at NextAddr and sends to TopAddr
  mbox_port_decode #(
    .AddrW(AddrW), .InboxAddr(NextAddr), .OutboxAddr(TopAddr)
  ) u_decA (
    .addr(aAddr), .ceN(aCeN), .weN(aWeN), .oeN(aOeN), .busyN(aBusyN),
    .postMsg(aPost), .takeMsg(aTake)
  );

  // side B receives at TopAddr and sends to NextAddr
  mbox_port_decode #(
    .AddrW(AddrW), .InboxAddr(TopAddr), .OutboxAddr(NextAddr)
  ) u_decB (
    .addr(bAddr), .ceN(bCeN), .weN(bWeN), .oeN(bOeN), .busyN(bBusyN),
    .postMsg(bPost), .takeMsg(bTake)
  );

  always_comb begin
    strobes.setA = bPost;
    strobes.clrA = aTake;
    strobes.setB = aPost;
    strobes.clrB = bTake;
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
#(
  parameter int NumSides = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  mboxStrobeT          strobes,
  output logic [NumSides-1:0] pending
);
  logic [NumSides-1:0] setV, clrV;

  assign setV = {strobes.setB, strobes.setA};
  assign clrV = {strobes.clrB, strobes.clrA};

  for (genvar s = 0; s < NumSides; s++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        pending[s] <= 1'b0;
      else if (setV[s]) pending[s] <= 1'b1;  // set wins over a same-edge clear
      else if (clrV[s]) pending[s] <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
#(
  parameter int AddrW = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] aAddr,
  input  logic             aCeN,
  input  logic             aWeN,
  input  logic             aOeN,
  input  logic             aBusyN,
  input  logic [AddrW-1:0] bAddr,
  input  logic             bCeN,
  input  logic             bWeN,
  input  logic             bOeN,
  input  logic             bBusyN,
  output logic             aIntN,
  output logic             bIntN
);
  localparam int NumSides = 2;

  mboxStrobeT          strobes;
  logic [NumSides-1:0] pending;

  mbox_ctrl #(.AddrW(AddrW)) u_ctrl (
    .aAddr(aAddr), .aCeN(aCeN), .aWeN(aWeN), .aOeN(aOeN), .aBusyN(aBusyN),
    .bAddr(bAddr), .bCeN(bCeN), .bWeN(bWeN), .bOeN(bOeN), .bBusyN(bBusyN),
    .strobes(strobes)
  );

  mbox_flags #(.NumSides(NumSides)) u_flags (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pending(pending)
  );

  assign aIntN = !pending[0];
  assign bIntN = !pending[1];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int AddrW = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic [AddrW-1:0] aAddr,
  input logic             aCeN,
  input logic             aWeN,
  input logic             aOeN,
  input logic             aBusyN,
  input logic [AddrW-1:0] bAddr,
  input logic             bCeN,
  input logic             bWeN,
  input logic             bOeN,
  input logic             bBusyN,
  input logic             aIntN,
  input logic             bIntN
);
  localparam logic [AddrW-1:0] HiAddr = '1;
  localparam logic [AddrW-1:0] LoAddr = HiAddr - 1'b1;

  logic aSends, bSends, aReads, bReads;
  assign aSends = !aCeN && !aWeN && aBusyN && (aAddr == HiAddr);
  assign bSends = !bCeN && !bWeN && bBusyN && (bAddr == LoAddr);
  assign aReads = !aCeN && !aOeN && aBusyN && (aAddr == LoAddr);
  assign bReads = !bCeN && !bOeN && bBusyN && (bAddr == HiAddr);

  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (aIntN && bIntN));
  // also covers R7: a same-edge clear does not cancel the set
  assert_send_to_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    aSends |=> !bIntN);
  assert_send_to_a_R3: assert property (@(posedge clk) disable iff (!rstN)
    bSends |=> !aIntN);
  assert_read_clears_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bReads && !aSends) |=> bIntN);
  assert_read_clears_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aReads && !bSends) |=> aIntN);
  assert_busy_freezes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!aBusyN && !bBusyN) |=> ($stable(aIntN) && $stable(bIntN)));
  assert_quiet_b_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!aSends && !bReads) |=> $stable(bIntN));
  assert_quiet_a_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!bSends && !aReads) |=> $stable(aIntN));
endmodule

bind mbox_irq mbox_irq_chk #(.AddrW(AddrW)) u_chk (
  .clk(clk), .rstN(rstN),
  .aAddr(aAddr), .aCeN(aCeN), .aWeN(aWeN), .aOeN(aOeN), .aBusyN(aBusyN),
  .bAddr(bAddr), .bCeN(bCeN), .bWeN(bWeN), .bOeN(bOeN), .bBusyN(bBusyN),
  .aIntN(aIntN), .bIntN(bIntN)
);

// File: tb/mbox_irq_tb.sv
module mbox_irq_tb;
  localparam int W = 14;
  localparam logic [W-1:0] TOP  = 14'h3FFF;
  localparam logic [W-1:0] NEXT = 14'h3FFE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aAddr = '0, bAddr = '0;
  logic aCeN = 1, aWeN = 1, aOeN = 1, aBusyN = 1;
  logic bCeN = 1, bWeN = 1, bOeN = 1, bBusyN = 1;
  logic aIntN, bIntN;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference: 1 = interrupt pending
  bit modA = 0, modB = 0;

  always #2 clk = ~clk;

  mbox_irq #(.AddrW(W)) u_dut (
    .clk(clk), .rstN(rstN),
    .aAddr(aAddr), .aCeN(aCeN), .aWeN(aWeN), .aOeN(aOeN), .aBusyN(aBusyN),
    .bAddr(bAddr), .bCeN(bCeN), .bWeN(bWeN), .bOeN(bOeN), .bBusyN(bBusyN),
    .aIntN(aIntN), .bIntN(bIntN)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modA = 0;
      modB = 0;
    end else begin
      bit sA, cA, sB, cB;
      sB = (aCeN == 0) && (aWeN == 0) && (aBusyN == 1) && (aAddr == TOP);
      sA = (bCeN == 0) && (bWeN == 0) && (bBusyN == 1) && (bAddr == NEXT);
      cA = (aCeN == 0) && (aOeN == 0) && (aBusyN == 1) && (aAddr == NEXT);
      cB = (bCeN == 0) && (bOeN == 0) && (bBusyN == 1) && (bAddr == TOP);
      if (sA) modA = 1; else if (cA) modA = 0;
      if (sB) modB = 1; else if (cB) modB = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (aIntN !== !modA || bIntN !== !modB) begin
        errors++;
        $display("FAIL %s model: aIntN=%b bIntN=%b expected %b %b",
                 curReq, aIntN, bIntN, !modA, !modB);
      end
    end
  end

  task automatic idle();
    aAddr = '0; aCeN = 1; aWeN = 1; aOeN = 1; aBusyN = 1;
    bAddr = '0; bCeN = 1; bWeN = 1; bOeN = 1; bBusyN = 1;
  endtask

  task automatic sideA(input logic [W-1:0] ad, input logic ce, we, oe, bz);
    aAddr = ad; aCeN = ce; aWeN = we; aOeN = oe; aBusyN = bz;
  endtask

  task automatic sideB(input logic [W-1:0] ad, input logic ce, we, oe, bz);
    bAddr = ad; bCeN = ce; bWeN = we; bOeN = oe; bBusyN = bz;
  endtask

  // called one negedge after the stimulus edge
  task automatic expect2(input logic expA, input logic expB, input string req);
    checks++;
    if (aIntN !== expA || bIntN !== expB) begin
      errors++;
      $display("FAIL %s: aIntN=%b bIntN=%b expected %b %b",
               req, aIntN, bIntN, expA, expB);
    end
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    expect2(1, 1, "R1 during reset");
    rstN = 1;
    @(negedge clk);
    expect2(1, 1, "R1 after reset");

    curReq = "R2";
    @(negedge clk); sideA(TOP, 0, 0, 1, 1); step();
    expect2(1, 0, "R2 A writes TOP");

    curReq = "R9";
    repeat (5) @(negedge clk);
    expect2(1, 0, "R9 hold over idle");

    curReq = "R8";
    @(negedge clk); sideA(TOP, 0, 1, 0, 1); step();
    expect2(1, 0, "R8 A reads B mailbox");

    curReq = "R6";
    @(negedge clk); sideB(TOP, 0, 1, 0, 0); step();
    expect2(1, 0, "R6 busy B read no clear");

    curReq = "R4";
    @(negedge clk); sideB(TOP, 0, 0, 0, 1); step();
    expect2(1, 1, "R4 B reads TOP with write strobe low");

    curReq = "R3";
    @(negedge clk); sideB(NEXT, 0, 0, 1, 1); step();
    expect2(0, 1, "R3 B writes NEXT");

    curReq = "R8";
    @(negedge clk); sideA(NEXT, 0, 0, 1, 1); sideB(TOP, 0, 0, 1, 1); step();
    expect2(0, 1, "R8 own-mailbox writes");
    @(negedge clk); sideA(TOP, 1, 0, 0, 1); step();
    expect2(0, 1, "R8 chip enable high");
    @(negedge clk); sideA(NEXT, 0, 1, 1, 1); step();
    expect2(0, 1, "R8 read with oe high");
    @(negedge clk); sideA(TOP - 2, 0, 0, 1, 1); sideB(NEXT - 1, 0, 0, 1, 1); step();
    expect2(0, 1, "R8 neighbour addresses");

    curReq = "R5";
    @(negedge clk); sideA(NEXT, 0, 1, 0, 1); step();
    expect2(1, 1, "R5 A reads NEXT");

    curReq = "R6";
    @(negedge clk); sideA(TOP, 0, 0, 1, 0); step();
    expect2(1, 1, "R6 busy A write no set");

    curReq = "R7";
    @(negedge clk); sideA(TOP, 0, 0, 1, 1); sideB(TOP, 0, 1, 0, 1); step();
    expect2(1, 0, "R7 set beats clear on B");
    @(negedge clk); sideB(NEXT, 0, 0, 1, 1); sideA(NEXT, 0, 1, 0, 1); step();
    expect2(0, 0, "R7 set beats clear on A");

    curReq = "R1";
    @(negedge clk); rstN = 0;
    @(negedge clk);
    expect2(1, 1, "R1 reset mid-run");
    rstN = 1;

    curReq = "R9";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      case ($urandom % 3)
        0: aAddr = TOP;
        1: aAddr = NEXT;
        default: aAddr = W'($urandom);
      endcase
      case ($urandom % 3)
        0: bAddr = TOP;
        1: bAddr = NEXT;
        default: bAddr = W'($urandom);
      endcase
      aCeN = ($urandom % 4) == 0; aWeN = $urandom % 2; aOeN = $urandom % 2;
      bCeN = ($urandom % 4) == 0; bWeN = $urandom % 2; bOeN = $urandom % 2;
      aBusyN = ($urandom % 4) != 0; bBusyN = ($urandom % 4) != 0;
    end
    @(negedge clk); idle();
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule